// File: doc/BRIEF.md
# Windowed Integer Register File

This block holds the integer registers of a RISC core. Software always sees 32 architectural register numbers. Numbers 0 to 7 are global registers that are shared by every context. Numbers 8 to 31 form a 24-register window, and a current-window pointer selects that window from a larger physical array. The window is made of three groups of eight. Numbers 8 to 15 are the outgoing argument registers, 16 to 23 are private locals, and 24 to 31 are the incoming argument registers. The outgoing group of a window is the same storage as the incoming group of the window one step below it. Arguments therefore pass between procedures without any copying.

Each cycle the block serves two combinational reads and one write. A write commits at the clock edge. Three controls move the pointer, and none of them is tied to call or return. Save allocates a window by stepping the pointer down by one, modulo the window count. Restore releases a window by stepping it up by one. Trap entry steps down like save, but it ignores the invalid-window mask. Before a save or restore moves the pointer, the bit of the target window in the mask is tested. If that bit is set, the pointer stays where it is and an overflow or underflow flag is raised for supervisor software. Spilling to memory is not part of this block.

Top module: `win_regfile`

## Requirements
- R1: After reset, `cwp` is 0, `win_ovf` and `win_unf` are 0, and every architectural register reads as zero.
- R2: Architectural registers 0 to 7 refer to the same storage whatever the pointer is. A value written there reads back unchanged after any number of window moves.
- R3: Register 0 always reads as zero, and a write to it has no effect.
- R4: A save with `wim[(cwp-1) mod NWIN]` clear, and no trap, sets `cwp` to `(cwp-1) mod NWIN` in the next cycle. This includes the wrap from 0 to NWIN-1.
- R5: Register 8+k (k = 0..7) of window w and register 24+k of window `(w-1) mod NWIN` are the same storage.
- R6: A restore with `wim[(cwp+1) mod NWIN]` clear, and neither save nor trap, sets `cwp` to `(cwp+1) mod NWIN` in the next cycle. This includes the wrap from NWIN-1 to 0.
- R7: A save whose target bit in `wim` is set leaves `cwp` unchanged. `win_ovf` is then 1 for exactly the cycle after the request.
- R8: A restore whose target bit in `wim` is set leaves `cwp` unchanged. `win_unf` is then 1 for exactly the cycle after the request.
- R9: Trap entry sets `cwp` to `(cwp-1) mod NWIN` in the next cycle, whatever `wim` holds, and raises no flag.
- R10: When several controls are asserted in the same cycle, trap entry takes priority over save, and save takes priority over restore. Only the winning control acts, and the flags are never both 1.
- R11: Registers 16 to 23 are private to each window. Writing them in one window leaves the same numbers in every other window unchanged.
- R12: Both read ports return data combinationally and independently. A write lands at the clock edge and uses the window mapping from before that edge, even when the pointer moves on the same edge.
- R13: A read of the register being written in the same cycle returns the new write data, resolved through the current mapping (write-first). This does not apply to register 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rs1_addr | input | 5 | Architectural number for read port 1 |
| rs1_data | output | XLEN | Read port 1 data |
| rs2_addr | input | 5 | Architectural number for read port 2 |
| rs2_data | output | XLEN | Read port 2 data |
| we | input | 1 | Write enable |
| rd_addr | input | 5 | Architectural destination number |
| wr_data | input | XLEN | Write data |
| save_req | input | 1 | Allocate a window (checked against the mask) |
| restore_req | input | 1 | Release a window (checked against the mask) |
| trap_req | input | 1 | Allocate a window without the mask check |
| wim | input | NWIN | Invalid-window mask, one bit per window |
| cwp | output | log2(NWIN) | Current window pointer |
| win_ovf | output | 1 | Save was refused by the mask |
| win_unf | output | 1 | Restore was refused by the mask |

## Verification
Read data depends only on the current pointer, the register contents and the write inputs of the same cycle. The bench therefore compares it in the cycle the addresses are applied, including the same-cycle bypass. Register writes, pointer moves and both flags appear exactly one clock edge after the request. So each step drives its inputs just after a falling edge and samples shortly afterwards. A behavioural model, updated on the rising edge, has by then absorbed the previous cycle's request. Flag and pointer effects are therefore judged one step after their stimulus, and every step compares both read ports, the pointer and both flags.

// File: rtl/wrf_pkg.sv
package wrf_pkg;
    localparam int unsigned ARCH_AW  = 5;
    localparam int unsigned GRP_SZ   = 8;
    localparam int unsigned NGLOBAL  = 8;
    localparam int unsigned WIN_STEP = 16;

    typedef enum logic [1:0] {
        RGN_GLOBAL = 2'd0,
        RGN_OUT    = 2'd1,
        RGN_LOCAL  = 2'd2,
        RGN_IN     = 2'd3
    } region_e;
endpackage

// File: rtl/wrf_addr_map.sv
module wrf_addr_map
    import wrf_pkg::*;
#(
    parameter int unsigned NWIN = 8,
    parameter int unsigned CW   = 3,
    parameter int unsigned PAW  = 8
) (
    input  logic [ARCH_AW-1:0] arch,
    input  logic [CW-1:0]      cwp,
    output logic [PAW-1:0]     phys
);
    region_e        rgn;
    logic [CW-1:0]  win_sel;
    logic [PAW-1:0] win_base;
    logic [PAW-1:0] grp_off;

    always_comb begin
        rgn = region_e'(arch[4:3]);
        // outgoing group lives in the window one step below
        if (rgn == RGN_OUT) begin
            win_sel = (cwp == '0) ? CW'(NWIN - 1) : cwp - 1'b1;
        end else begin
            win_sel = cwp;
        end
        win_base = PAW'(win_sel) * PAW'(WIN_STEP);
        grp_off  = (rgn == RGN_LOCAL) ? PAW'(GRP_SZ) : PAW'(0);
        if (rgn == RGN_GLOBAL) begin
            phys = PAW'(arch);
        end else begin
            phys = PAW'(NGLOBAL) + win_base + grp_off + PAW'(arch[2:0]);
        end
    end
endmodule

// File: rtl/wrf_window_ctl.sv
module wrf_window_ctl #(
    parameter int unsigned NWIN = 8,
    parameter int unsigned CW   = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            save_req,
    input  logic            restore_req,
    input  logic            trap_req,
    input  logic [NWIN-1:0] wim,
    output logic [CW-1:0]   cwp,
    output logic            win_ovf,
    output logic            win_unf
);
    typedef struct packed {
        logic [CW-1:0] cwp;
        logic          ovf;
        logic          unf;
    } wstate_t;

    wstate_t st_d, st_q;

    function automatic logic [CW-1:0] wdec(input logic [CW-1:0] w);
        return (w == '0) ? CW'(NWIN - 1) : w - 1'b1;
    endfunction

    function automatic logic [CW-1:0] winc(input logic [CW-1:0] w);
        return (w == CW'(NWIN - 1)) ? '0 : w + 1'b1;
    endfunction

    logic [CW-1:0] below_w, above_w;

    always_comb begin
        below_w = wdec(st_q.cwp);
        above_w = winc(st_q.cwp);
        st_d     = st_q;
        st_d.ovf = 1'b0;
        st_d.unf = 1'b0;
        if (trap_req) begin
            st_d.cwp = below_w;
        end else if (save_req) begin
            if (wim[below_w]) st_d.ovf = 1'b1;
            else              st_d.cwp = below_w;
        end else if (restore_req) begin
            if (wim[above_w]) st_d.unf = 1'b1;
            else              st_d.cwp = above_w;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cwp     = st_q.cwp;
    assign win_ovf = st_q.ovf;
    assign win_unf = st_q.unf;

    p_save_moves_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (save_req && !trap_req && !wim[wdec(cwp)]) |=> (cwp == wdec($past(cwp))));
    p_restore_moves_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (restore_req && !save_req && !trap_req && !wim[winc(cwp)]) |=> (cwp == winc($past(cwp))));
    p_ovf_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
        win_ovf |-> (cwp == $past(cwp)));
    p_unf_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
        win_unf |-> (cwp == $past(cwp)));
    p_trap_moves_r9: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req |=> (cwp == wdec($past(cwp)) && !win_ovf && !win_unf));
    p_flags_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(win_ovf && win_unf));
    p_save_beats_restore_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (save_req && restore_req) |=> !win_unf);
endmodule

// File: rtl/wrf_storage.sv
module wrf_storage #(
    parameter int unsigned XLEN  = 32,
    parameter int unsigned NPHYS = 136,
    parameter int unsigned PAW   = 8,
    parameter int unsigned NRD   = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      we,
    input  logic [PAW-1:0]            wa,
    input  logic [XLEN-1:0]           wd,
    input  logic [NRD-1:0][PAW-1:0]   ra,
    output logic [NRD-1:0][XLEN-1:0]  rd
);
    logic [XLEN-1:0] mem_d [NPHYS];
    logic [XLEN-1:0] mem_q [NPHYS];

    always_comb begin
        mem_d = mem_q;
        if (we && wa != '0) mem_d[wa] = wd;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < int'(NPHYS); i++) mem_q[i] <= '0;
        end else begin
            mem_q <= mem_d;
        end
    end

    for (genvar g = 0; g < NRD; g++) begin : g_rd
        assign rd[g] = mem_q[ra[g]];
    end
endmodule

// File: rtl/win_regfile.sv
module win_regfile
    import wrf_pkg::*;
#(
    parameter int unsigned XLEN = 32,
    parameter int unsigned NWIN = 8,
    localparam int unsigned CW    = (NWIN > 1) ? $clog2(NWIN) : 1,
    localparam int unsigned NPHYS = NGLOBAL + WIN_STEP * NWIN,
    localparam int unsigned PAW   = $clog2(NPHYS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [4:0]         rs1_addr,
    output logic [XLEN-1:0]    rs1_data,
    input  logic [4:0]         rs2_addr,
    output logic [XLEN-1:0]    rs2_data,
    input  logic               we,
    input  logic [4:0]         rd_addr,
    input  logic [XLEN-1:0]    wr_data,
    input  logic               save_req,
    input  logic               restore_req,
    input  logic               trap_req,
    input  logic [NWIN-1:0]    wim,
    output logic [CW-1:0]      cwp,
    output logic               win_ovf,
    output logic               win_unf
);
    localparam int unsigned NRD = 2;

    logic [NRD-1:0][ARCH_AW-1:0] rarch;
    logic [NRD-1:0][PAW-1:0]     rphys;
    logic [NRD-1:0][XLEN-1:0]    raw;
    logic [NRD-1:0][XLEN-1:0]    rout;
    logic [PAW-1:0]              wphys;

    assign rarch[0] = rs1_addr;
    assign rarch[1] = rs2_addr;

    wrf_window_ctl #(.NWIN(NWIN), .CW(CW)) u_ctl (
        .clk(clk), .rst_n(rst_n),
        .save_req(save_req), .restore_req(restore_req), .trap_req(trap_req),
        .wim(wim), .cwp(cwp), .win_ovf(win_ovf), .win_unf(win_unf)
    );

    wrf_addr_map #(.NWIN(NWIN), .CW(CW), .PAW(PAW)) u_wmap (
        .arch(rd_addr), .cwp(cwp), .phys(wphys)
    );

    for (genvar g = 0; g < NRD; g++) begin : g_port
        wrf_addr_map #(.NWIN(NWIN), .CW(CW), .PAW(PAW)) u_rmap (
            .arch(rarch[g]), .cwp(cwp), .phys(rphys[g])
        );
        always_comb begin
            if (rphys[g] == '0)                    rout[g] = '0;
            else if (we && wphys == rphys[g])      rout[g] = wr_data;
            else                                   rout[g] = raw[g];
        end
    end

    wrf_storage #(.XLEN(XLEN), .NPHYS(NPHYS), .PAW(PAW), .NRD(NRD)) u_mem (
        .clk(clk), .rst_n(rst_n), .we(we), .wa(wphys), .wd(wr_data),
        .ra(rphys), .rd(raw)
    );

    assign rs1_data = rout[0];
    assign rs2_data = rout[1];

    p_g0_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rs1_addr == '0) |-> (rs1_data == '0));
    p_bypass_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (we && rd_addr != '0 && rd_addr == rs2_addr) |-> (rs2_data == wr_data));
    p_global_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(we) && $past(rd_addr) != '0 && $past(rd_addr) < 5'd8
         && rs1_addr == $past(rd_addr) && !(we && rd_addr == rs1_addr))
        |-> (rs1_data == $past(wr_data)));
endmodule

// File: tb/tb_win_regfile.sv
`timescale 1ns/1ps
module tb_win_regfile;
    localparam int NWIN = 8;
    localparam int XLEN = 32;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [4:0]      rs1_addr = '0, rs2_addr = '0, rd_addr = '0;
    logic [XLEN-1:0] rs1_data, rs2_data, wr_data = '0;
    logic            we = 1'b0, save_req = 1'b0, restore_req = 1'b0, trap_req = 1'b0;
    logic [NWIN-1:0] wim = '0;
    logic [2:0]      cwp;
    logic            win_ovf, win_unf;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #10 clk = ~clk;

    win_regfile #(.XLEN(XLEN), .NWIN(NWIN)) dut (
        .clk(clk), .rst_n(rst_n),
        .rs1_addr(rs1_addr), .rs1_data(rs1_data),
        .rs2_addr(rs2_addr), .rs2_data(rs2_data),
        .we(we), .rd_addr(rd_addr), .wr_data(wr_data),
        .save_req(save_req), .restore_req(restore_req), .trap_req(trap_req),
        .wim(wim), .cwp(cwp), .win_ovf(win_ovf), .win_unf(win_unf)
    );

    // behavioural reference: globals, per-window locals, per-window ins
    logic [XLEN-1:0] m_glob [8];
    logic [XLEN-1:0] m_loc  [NWIN][8];
    logic [XLEN-1:0] m_in   [NWIN][8];
    int m_cwp = 0;
    bit m_ovf = 0, m_unf = 0;

    function automatic logic [XLEN-1:0] m_stored(int a, int c);
        if (a == 0)  return '0;
        if (a < 8)   return m_glob[a];
        if (a < 16)  return m_in[(c + NWIN - 1) % NWIN][a - 8];
        if (a < 24)  return m_loc[c][a - 16];
        return m_in[c][a - 24];
    endfunction

    function automatic logic [XLEN-1:0] m_read(int a);
        if (a == 0) return '0;
        if (we && int'(rd_addr) == a) return wr_data;
        return m_stored(a, m_cwp);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 8; i++) m_glob[i] = '0;
            for (int w = 0; w < NWIN; w++)
                for (int i = 0; i < 8; i++) begin
                    m_loc[w][i] = '0;
                    m_in[w][i]  = '0;
                end
            m_cwp = 0; m_ovf = 0; m_unf = 0;
        end else begin
            int a;
            int t;
            a = int'(rd_addr);
            if (we && a != 0) begin
                if (a < 8)       m_glob[a] = wr_data;
                else if (a < 16) m_in[(m_cwp + NWIN - 1) % NWIN][a - 8] = wr_data;
                else if (a < 24) m_loc[m_cwp][a - 16] = wr_data;
                else             m_in[m_cwp][a - 24] = wr_data;
            end
            m_ovf = 0; m_unf = 0;
            if (trap_req) begin
                m_cwp = (m_cwp + NWIN - 1) % NWIN;
            end else if (save_req) begin
                t = (m_cwp + NWIN - 1) % NWIN;
                if (wim[t]) m_ovf = 1; else m_cwp = t;
            end else if (restore_req) begin
                t = (m_cwp + 1) % NWIN;
                if (wim[t]) m_unf = 1; else m_cwp = t;
            end
        end
    end

    task automatic chk(string tag, string what, logic [XLEN-1:0] act, logic [XLEN-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic step(string tag, bit s, bit r, bit t, bit w,
                        logic [4:0] wa, logic [XLEN-1:0] wd,
                        logic [4:0] a1, logic [4:0] a2);
        @(negedge clk);
        save_req = s; restore_req = r; trap_req = t;
        we = w; rd_addr = wa; wr_data = wd;
        rs1_addr = a1; rs2_addr = a2;
        #2;
        chk(tag, "rs1_data", rs1_data, m_read(int'(a1)));
        chk(tag, "rs2_data", rs2_data, m_read(int'(a2)));
        chk(tag, "cwp", XLEN'(cwp), XLEN'(m_cwp));
        chk(tag, "win_ovf", XLEN'(win_ovf), XLEN'(m_ovf));
        chk(tag, "win_unf", XLEN'(win_unf), XLEN'(m_unf));
    endtask

    task automatic idle(string tag, logic [4:0] a1, logic [4:0] a2);
        step(tag, 0, 0, 0, 0, 5'd0, '0, a1, a2);
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            summary();
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state, all registers zero
        for (int i = 0; i < 32; i += 2) idle("R1", 5'(i), 5'(i + 1));
        // R3: write to register 0 ignored
        step("R3", 0, 0, 0, 1, 5'd0, 32'hDEAD_BEEF, 5'd0, 5'd0);
        idle("R3", 5'd0, 5'd1);
        // R13: same-cycle write-first bypass on both ports
        step("R13", 0, 0, 0, 1, 5'd5, 32'h1234_5678, 5'd5, 5'd5);
        step("R13", 0, 0, 0, 1, 5'd20, 32'hAAAA_0001, 5'd20, 5'd5);
        // R2: globals survive window moves
        for (int i = 1; i < 8; i++) step("R2", 0, 0, 0, 1, 5'(i), 32'h6000_0000 + i, 5'(i), 5'd0);
        step("R2", 1, 0, 0, 0, 5'd0, '0, 5'd1, 5'd2);
        for (int i = 1; i < 8; i += 2) idle("R2", 5'(i), 5'(i + 1));
        step("R2", 0, 1, 0, 0, 5'd0, '0, 5'd3, 5'd7);
        // R11: locals private per window
        for (int i = 16; i < 24; i++) step("R11", 0, 0, 0, 1, 5'(i), 32'h1100_0000 + i, 5'(i), 5'd0);
        step("R11", 1, 0, 0, 0, 5'd0, '0, 5'd16, 5'd17);
        for (int i = 16; i < 24; i++) step("R11", 0, 0, 0, 1, 5'(i), 32'h2200_0000 + i, 5'(i), 5'd18);
        step("R11", 0, 1, 0, 0, 5'd0, '0, 5'd16, 5'd23);
        for (int i = 16; i < 24; i += 2) idle("R11", 5'(i), 5'(i + 1));
        // R5: outs of caller become ins of callee after save
        for (int i = 8; i < 16; i++) step("R5", 0, 0, 0, 1, 5'(i), 32'h5500_0000 + i, 5'(i), 5'd0);
        step("R5", 1, 0, 0, 0, 5'd0, '0, 5'd24, 5'd8);
        for (int i = 24; i < 32; i += 2) idle("R5", 5'(i), 5'(i + 1));
        // R6: ins written in callee appear as outs after restore
        for (int i = 24; i < 32; i++) step("R6", 0, 0, 0, 1, 5'(i), 32'h6600_0000 + i, 5'(i), 5'd0);
        step("R6", 0, 1, 0, 0, 5'd0, '0, 5'd8, 5'd9);
        for (int i = 8; i < 16; i += 2) idle("R6", 5'(i), 5'(i + 1));
        // R4: full rotation by save with wrap from 0, then R6 back with wrap
        for (int k = 0; k < NWIN; k++) step("R4", 1, 0, 0, 0, 5'd0, '0, 5'd24, 5'd16);
        idle("R4", 5'd8, 5'd24);
        for (int k = 0; k < NWIN; k++) step("R6", 0, 1, 0, 0, 5'd0, '0, 5'd24, 5'd16);
        idle("R6", 5'd8, 5'd24);
        // R7: overflow at mask bit of window below
        wim = 8'b1000_0000;
        step("R7", 1, 0, 0, 0, 5'd0, '0, 5'd16, 5'd24);
        idle("R7", 5'd16, 5'd24);
        idle("R7", 5'd16, 5'd8);
        // R9: trap ignores mask
        step("R9", 0, 0, 1, 0, 5'd0, '0, 5'd16, 5'd24);
        idle("R9", 5'd16, 5'd24);
        // R8: underflow on restore toward window 0
        wim = 8'b0000_0001;
        step("R8", 0, 1, 0, 0, 5'd0, '0, 5'd24, 5'd8);
        idle("R8", 5'd24, 5'd8);
        idle("R8", 5'd24, 5'd8);
        // R10: simultaneous controls
        wim = '0;
        step("R10", 1, 1, 0, 0, 5'd0, '0, 5'd16, 5'd8);
        idle("R10", 5'd16, 5'd8);
        wim = 8'b0010_0000;
        step("R10", 1, 1, 0, 0, 5'd0, '0, 5'd16, 5'd8);
        idle("R10", 5'd16, 5'd8);
        step("R10", 1, 1, 1, 0, 5'd0, '0, 5'd16, 5'd8);
        idle("R10", 5'd16, 5'd8);
        wim = '0;
        // R12: write lands with the mapping before a same-edge move
        step("R12", 1, 0, 0, 1, 5'd17, 32'hC0DE_0017, 5'd17, 5'd9);
        idle("R12", 5'd17, 5'd25);
        step("R12", 0, 1, 0, 1, 5'd9, 32'hC0DE_0009, 5'd17, 5'd9);
        idle("R12", 5'd17, 5'd9);
        idle("R12", 5'd2, 5'd30);
        done = 1;
        summary();
    end
endmodule